// File: doc/BRIEF.md
# Three-Level Address Translation Walker

This block turns a 64-bit virtual address into a physical address. In the general case it reads a three-level page table from memory, one 64-bit entry per level, and checks access rights against the privilege mode of the request. Three kinds of request finish without touching memory: physical-mode requests, addresses that are not properly sign-extended, and addresses inside a direct-mapped kernel window.

A request carries the virtual address, an access type, a privilege mode, a physical-mode flag and the table root. It is taken only while the walker is idle. Requests made while a walk is running are dropped. Table entries are fetched over a simple memory port: each read is a one-cycle request pulse, and the answer returns some cycles later with a valid strobe. The result appears for exactly one cycle with a done pulse. It is either a success with the physical address and the permitted operations, or a fault code.

Access type encoding: 0 read, 1 write, 2 execute; the value 3 is handled as a read. Mode index: 0 kernel, 3 user, with 1 and 2 as intermediate modes.

Top module: `vtrans_walker`

## Requirements
- R1: With the physical flag set, the result succeeds one cycle after acceptance. `paddr` equals the request address and `perm` is 3'b111 (bit 0 read, bit 1 write, bit 2 execute). No memory read is issued.
- R2: Without the physical flag, an address whose bits 63:43 are not all equal to bit 63 fails with fault code 1 (access violation) one cycle after acceptance, and no read is issued.
- R3: A canonical address with bit 63 set and bits 42:41 equal to 2'b10 is a kernel window. In mode 0 it succeeds with no read, with `perm` 3'b111, physical bits 39:0 taken from the address, address bit 40 placed at physical bit 43, and every other bit zero. In any other mode it fails with code 1.
- R4: Other canonical addresses are walked with three reads, in order. The first reads at `ptbr` + 8*addr[42:33]. The second reads at B2 + 8*addr[32:23] and the third at B3 + 8*addr[22:13]. Each base B is bits 63:32 of the entry just read, shifted left by 13.
- R5: A first- or second-level entry with bit 0 (valid) clear stops the walk with code 0 (translation not valid). A valid entry there whose bit 8 (kernel read enable) is clear stops it with code 1.
- R6: A third-level entry with bit 0 clear fails with code 0 after exactly three reads.
- R7: At the third level, read and execute are allowed when entry bit 8+mode is set, and write is allowed when entry bit 12+mode is set. If the requested operation is not allowed, the result is code 1.
- R8: Allowed operations are then cleared by entry bits 1 (read), 2 (write) and 3 (execute). If the requested one is cleared, the code is 3 for execute, 4 for write and 2 for read. Otherwise the result succeeds with `perm` equal to the remaining set and `paddr` equal to the third-level frame base ORed with address bits 12:0.
- R9: `done` is high for one cycle per accepted request. On a fault, `ok` is low and both `paddr` and `perm` are zero. After reset, `done`, `busy` and `mem_req_valid` are low.
- R10: While `busy` is high, requests are ignored and produce no result. `mem_req_valid` is a single-cycle pulse per level and appears only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 64 | Virtual address |
| req_access | input | 2 | Operation: 0 read, 1 write, 2 execute |
| req_mode | input | 2 | Privilege mode index, 0 kernel |
| req_phys | input | 1 | Physical-mode flag, bypasses translation |
| ptbr | input | 64 | Physical base of the first-level table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Table read request pulse |
| mem_req_addr | output | 64 | Table read address |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 64 | Table entry returned |
| done | output | 1 | Result valid for this cycle |
| ok | output | 1 | Translation succeeded |
| fault | output | 3 | 0 not valid, 1 access violation, 2 read, 3 execute, 4 write fault |
| paddr | output | 64 | Physical address |
| perm | output | 3 | Permitted operations, bit 0 read, 1 write, 2 execute |

## Verification
Two things can land in the same cycle: a new request arriving, and an in-flight walk handling a memory answer or finishing. This is provoked by holding a physical-mode request high for several cycles while a slow three-level walk is running. The outcome is judged by three things: exactly one result appears, it matches the walk and not the physical-mode request, and no extra done pulse follows. Memory latency is varied from one to three cycles so that the answer arrives at different points relative to the held request.

// File: rtl/vtw_pkg.sv
`timescale 1ns/1ps
package vtw_pkg;

   typedef enum logic [2:0] {
      FLT_TNV = 3'd0,
      FLT_ACV = 3'd1,
      FLT_FOR = 3'd2,
      FLT_FOE = 3'd3,
      FLT_FOW = 3'd4
   } vtw_fault_e;

   typedef struct packed {
      logic       ok;
      vtw_fault_e fault;
      logic [2:0] perm;
   } vtw_verdict_t;

   localparam logic [1:0] MODE_KERNEL   = 2'd0;
   localparam int         PTE_VALID_BIT = 0;
   localparam int         PTE_FO_LSB    = 1;
   localparam int         PTE_RD_EN_LSB = 8;
   localparam int         PTE_WR_EN_LSB = 12;

   function automatic logic [2:0] acc_need(logic [1:0] acc);
      case (acc)
         2'd1:    return 3'b010;
         2'd2:    return 3'b100;
         default: return 3'b001;
      endcase
   endfunction

endpackage

// File: rtl/vtw_index.sv
`timescale 1ns/1ps
module vtw_index #(
   parameter int ADDR_W  = 64,
   parameter int PG_BITS = 13,
   parameter int IDX_W   = 10,
   parameter int LEVELS  = 3,
   parameter int LVL_W   = 2
)(
   input  logic [ADDR_W-1:0] va,
   input  logic [LVL_W-1:0]  lvl,
   output logic [IDX_W-1:0]  idx
);
   logic [IDX_W-1:0] per_lvl [LEVELS];

   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      assign per_lvl[g] = va[PG_BITS + (LEVELS-1-g)*IDX_W +: IDX_W];
   end

   always_comb begin
      idx = '0;
      for (int k = 0; k < LEVELS; k++) begin
         if (lvl == LVL_W'(k)) idx = per_lvl[k];
      end
   end
endmodule

// File: rtl/vtw_front.sv
`timescale 1ns/1ps
module vtw_front import vtw_pkg::*; #(
   parameter int ADDR_W       = 64,
   parameter int IMPL_VA_BITS = 43,
   parameter int SP_KEEP_BITS = 40,
   parameter int SP_MOVE_TO   = 43,
   parameter int SP_RELOC     = 1
)(
   input  logic [ADDR_W-1:0] va,
   input  logic [1:0]        mode,
   input  logic              phys,
   output logic              direct,
   output vtw_verdict_t      verdict,
   output logic [ADDR_W-1:0] pa
);
   localparam int EXT_W = ADDR_W - IMPL_VA_BITS;

   logic              canon;
   logic              sp_hit;
   logic [ADDR_W-1:0] sp_pa;

   assign canon  = (va[ADDR_W-1:IMPL_VA_BITS] == {EXT_W{va[ADDR_W-1]}});
   assign sp_hit = va[ADDR_W-1] && (va[IMPL_VA_BITS-1 -: 2] == 2'b10);

   generate
      if (SP_RELOC != 0) begin : g_reloc
         always_comb begin
            sp_pa                     = '0;
            sp_pa[SP_KEEP_BITS-1:0]   = va[SP_KEEP_BITS-1:0];
            sp_pa[SP_MOVE_TO]         = va[SP_KEEP_BITS];
         end
      end else begin : g_flat
         always_comb begin
            sp_pa                   = '0;
            sp_pa[SP_KEEP_BITS:0]   = va[SP_KEEP_BITS:0];
         end
      end
   endgenerate

   always_comb begin
      direct  = 1'b1;
      verdict = '{ok: 1'b0, fault: FLT_ACV, perm: 3'b000};
      pa      = '0;
      if (phys) begin
         verdict = '{ok: 1'b1, fault: FLT_TNV, perm: 3'b111};
         pa      = va;
      end else if (!canon) begin
         verdict = '{ok: 1'b0, fault: FLT_ACV, perm: 3'b000};
      end else if (sp_hit) begin
         if (mode == MODE_KERNEL) begin
            verdict = '{ok: 1'b1, fault: FLT_TNV, perm: 3'b111};
            pa      = sp_pa;
         end
      end else begin
         direct = 1'b0;
      end
   end
endmodule

// File: rtl/vtw_pte_eval.sv
`timescale 1ns/1ps
module vtw_pte_eval import vtw_pkg::*; #(
   parameter int ADDR_W  = 64,
   parameter int PG_BITS = 13
)(
   input  logic [63:0]        pte,
   input  logic               last,
   input  logic [1:0]         mode,
   input  logic [2:0]         need,
   input  logic [PG_BITS-1:0] offset,
   output vtw_verdict_t       verdict,
   output logic [ADDR_W-1:0]  frame_base,
   output logic [ADDR_W-1:0]  pa
);
   logic       rd_ok, wr_ok;
   logic [2:0] granted, masked;
   logic       pte_unused_bits;

   assign pte_unused_bits = ^{pte[7:4], pte[31:16]};
   assign frame_base = ADDR_W'(pte[63:32]) << PG_BITS;
   assign rd_ok      = pte[PTE_RD_EN_LSB + int'(mode)];
   assign wr_ok      = pte[PTE_WR_EN_LSB + int'(mode)];
   assign granted    = {rd_ok, wr_ok, rd_ok};
   assign masked     = granted & ~pte[PTE_FO_LSB +: 3];

   always_comb begin
      verdict = '{ok: 1'b0, fault: FLT_TNV, perm: 3'b000};
      pa      = '0;
      if (!pte[PTE_VALID_BIT]) begin
         verdict.fault = FLT_TNV;
      end else if (!last) begin
         if (!pte[PTE_RD_EN_LSB]) verdict.fault = FLT_ACV;
         else                     verdict.ok    = 1'b1;
      end else if ((granted & need) == 3'b000) begin
         verdict.fault = FLT_ACV;
      end else if ((masked & need) == 3'b000) begin
         verdict.fault = need[2] ? FLT_FOE : (need[1] ? FLT_FOW : FLT_FOR);
      end else begin
         verdict.ok   = 1'b1;
         verdict.perm = masked;
         pa           = frame_base | ADDR_W'(offset);
      end
   end
endmodule

// File: rtl/vtrans_walker.sv
`timescale 1ns/1ps
module vtrans_walker import vtw_pkg::*; #(
   parameter int ADDR_W       = 64,
   parameter int IMPL_VA_BITS = 43,
   parameter int PG_BITS      = 13,
   parameter int IDX_W        = 10,
   parameter int LEVELS       = 3,
   parameter int SP_KEEP_BITS = 40,
   parameter int SP_MOVE_TO   = 43,
   parameter int SP_RELOC     = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic [1:0]        req_access,
   input  logic [1:0]        req_mode,
   input  logic              req_phys,
   input  logic [ADDR_W-1:0] ptbr,
   output logic              busy,
   output logic              mem_req_valid,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [63:0]       mem_rsp_data,
   output logic              done,
   output logic              ok,
   output logic [2:0]        fault,
   output logic [ADDR_W-1:0] paddr,
   output logic [2:0]        perm
);
   localparam int LVL_W       = (LEVELS > 1) ? $clog2(LEVELS) : 1;
   localparam int ENTRY_SHIFT = 3;
   localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

   generate
      if (IMPL_VA_BITS != PG_BITS + LEVELS*IDX_W) begin : g_bad_split
         $error("index fields do not cover the implemented address width");
      end
      if (ADDR_W < 32 + PG_BITS || SP_MOVE_TO >= ADDR_W || IMPL_VA_BITS >= ADDR_W) begin : g_bad_width
         $error("address width too small for frame or window layout");
      end
   endgenerate

   typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

   state_e            state_q;
   logic [ADDR_W-1:0] va_q, base_q, pa_q;
   logic [1:0]        mode_q;
   logic [2:0]        need_q, perm_q;
   logic [LVL_W-1:0]  lvl_q;
   logic              done_q, ok_q;
   vtw_fault_e        fault_q;

   logic              fe_direct;
   vtw_verdict_t      fe_verdict;
   logic [ADDR_W-1:0] fe_pa;
   logic [IDX_W-1:0]  cur_idx;
   vtw_verdict_t      pe_verdict;
   logic [ADDR_W-1:0] pe_base, pe_pa;
   logic              lvl_last, accept;

   vtw_front #(
      .ADDR_W(ADDR_W), .IMPL_VA_BITS(IMPL_VA_BITS),
      .SP_KEEP_BITS(SP_KEEP_BITS), .SP_MOVE_TO(SP_MOVE_TO), .SP_RELOC(SP_RELOC)
   ) u_front (
      .va(req_vaddr), .mode(req_mode), .phys(req_phys),
      .direct(fe_direct), .verdict(fe_verdict), .pa(fe_pa)
   );

   vtw_index #(
      .ADDR_W(ADDR_W), .PG_BITS(PG_BITS), .IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W)
   ) u_index (
      .va(va_q), .lvl(lvl_q), .idx(cur_idx)
   );

   assign lvl_last = (lvl_q == LAST_LVL);

   vtw_pte_eval #(
      .ADDR_W(ADDR_W), .PG_BITS(PG_BITS)
   ) u_eval (
      .pte(mem_rsp_data), .last(lvl_last), .mode(mode_q), .need(need_q),
      .offset(va_q[PG_BITS-1:0]), .verdict(pe_verdict), .frame_base(pe_base), .pa(pe_pa)
   );

   assign accept        = req_valid && (state_q == S_IDLE);
   assign busy          = (state_q != S_IDLE);
   assign mem_req_valid = (state_q == S_ISSUE);
   assign mem_req_addr  = base_q + (ADDR_W'(cur_idx) << ENTRY_SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         va_q    <= '0;
         base_q  <= '0;
         mode_q  <= '0;
         need_q  <= '0;
         lvl_q   <= '0;
         done_q  <= 1'b0;
         ok_q    <= 1'b0;
         fault_q <= FLT_TNV;
         pa_q    <= '0;
         perm_q  <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (accept) begin
                  va_q   <= req_vaddr;
                  mode_q <= req_mode;
                  need_q <= acc_need(req_access);
                  base_q <= ptbr;
                  lvl_q  <= '0;
                  if (fe_direct) begin
                     done_q  <= 1'b1;
                     ok_q    <= fe_verdict.ok;
                     fault_q <= fe_verdict.fault;
                     perm_q  <= fe_verdict.perm;
                     pa_q    <= fe_pa;
                  end else begin
                     state_q <= S_ISSUE;
                  end
               end
            end
            S_ISSUE: state_q <= S_WAIT;
            S_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!pe_verdict.ok || lvl_last) begin
                     state_q <= S_IDLE;
                     done_q  <= 1'b1;
                     ok_q    <= pe_verdict.ok;
                     fault_q <= pe_verdict.fault;
                     perm_q  <= pe_verdict.perm;
                     pa_q    <= pe_pa;
                  end else begin
                     base_q  <= pe_base;
                     lvl_q   <= lvl_q + 1'b1;
                     state_q <= S_ISSUE;
                  end
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign done  = done_q;
   assign ok    = ok_q;
   assign fault = fault_q;
   assign paddr = pa_q;
   assign perm  = perm_q;
endmodule

// File: rtl/vtw_checker.sv
`timescale 1ns/1ps
module vtw_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [63:0] req_vaddr,
   input logic [1:0]  req_mode,
   input logic        req_phys,
   input logic        busy,
   input logic        mem_req_valid,
   input logic        done,
   input logic        ok,
   input logic [2:0]  fault,
   input logic [63:0] paddr,
   input logic [2:0]  perm
);
   logic taken, canon_in, window_in;
   assign taken     = req_valid && !busy;
   assign canon_in  = (req_vaddr[63:43] == {21{req_vaddr[63]}});
   assign window_in = req_vaddr[63] && (req_vaddr[42:41] == 2'b10);

   assert_phys_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && req_phys) |=> (done && ok && perm == 3'b111 && paddr == $past(req_vaddr)));

   assert_phys_no_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && req_phys) |=> !mem_req_valid);

   assert_noncanon_acv_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && !req_phys && !canon_in) |=> (done && !ok && fault == 3'd1));

   assert_window_user_acv_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && !req_phys && canon_in && window_in && req_mode != 2'd0) |=> (done && !ok && fault == 3'd1));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_fault_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !ok) |-> (paddr == 64'd0 && perm == 3'b000));

   assert_read_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);

   assert_read_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> busy);
endmodule

bind vtrans_walker vtw_checker u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
   .req_mode(req_mode), .req_phys(req_phys), .busy(busy), .mem_req_valid(mem_req_valid),
   .done(done), .ok(ok), .fault(fault), .paddr(paddr), .perm(perm)
);

// File: tb/vtrans_walker_test.sv
`timescale 1ns/1ps
module vtrans_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_vaddr = '0;
   logic [1:0]  req_access = '0;
   logic [1:0]  req_mode = '0;
   logic        req_phys = 1'b0;
   logic [63:0] ptbr = '0;
   logic        busy, mem_req_valid, done, ok;
   logic [63:0] mem_req_addr, paddr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic [2:0]  fault, perm;

   always #10 clk = ~clk;

   vtrans_walker uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_access(req_access), .req_mode(req_mode), .req_phys(req_phys), .ptbr(ptbr),
      .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .ok(ok), .fault(fault), .paddr(paddr), .perm(perm)
   );

   typedef struct {
      bit          ok;
      bit [2:0]    fault;
      bit [63:0]   pa;
      bit [2:0]    perm;
      int          reads;
      int          start;
      string       tag;
   } exp_t;

   exp_t        exp_q[$];
   logic [63:0] rd_log[$];
   logic [63:0] pt_mem [logic [63:0]];
   int          n_checks = 0, n_fail = 0, extra_done = 0, lat = 1;
   int          pend_cnt = 0;
   logic [63:0] pend_addr = '0;

   localparam logic [31:0] F_V = 32'h1, F_FOR = 32'h2, F_FOW = 32'h4, F_FOE = 32'h8;
   localparam logic [31:0] F_KRE = 32'h100, F_URE = 32'h800, F_KWE = 32'h1000;
   localparam logic [63:0] ROOT = 64'h0010_0000;

   function automatic logic [63:0] rdm(logic [63:0] a);
      if (pt_mem.exists(a)) return pt_mem[a];
      return 64'd0;
   endfunction

   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (pend_cnt != 0) begin
         pend_cnt <= pend_cnt - 1;
         if (pend_cnt == 1) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= rdm(pend_addr);
         end
      end
      if (rst_n && mem_req_valid) begin
         pend_addr <= mem_req_addr;
         pend_cnt  <= lat;
         rd_log.push_back(mem_req_addr);
      end
   end

   task automatic check(bit cond, string tag, string what, logic [63:0] act, logic [63:0] expv);
      n_checks++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
      end
   endtask

   function automatic exp_t model(logic [63:0] va, int acc, int mode, bit phys, logic [63:0] root);
      exp_t        e;
      logic [63:0] b, pte, idx;
      bit          r, w;
      bit [2:0]    prot, need;
      e.ok = 0; e.fault = 3'd1; e.pa = 0; e.perm = 0; e.reads = 0; e.start = 0; e.tag = "";
      if (phys) begin e.ok = 1; e.pa = va; e.perm = 3'b111; return e; end
      if (va[63:43] != {21{va[63]}}) return e;
      if (va[63] && va[42:41] == 2'b10) begin
         if (mode != 0) return e;
         e.ok = 1; e.perm = 3'b111; e.pa = {20'h0, va[40], 3'b000, va[39:0]};
         return e;
      end
      b = root; pte = 0;
      for (int l = 0; l < 3; l++) begin
         idx = (va >> (13 + 10*(2-l))) & 64'h3ff;
         pte = rdm(b + idx*8);
         e.reads++;
         if (!pte[0]) begin e.fault = 3'd0; return e; end
         if (l < 2) begin
            if (!pte[8]) begin e.fault = 3'd1; return e; end
            b = {19'h0, pte[63:32], 13'h0};
         end
      end
      r = pte[8+mode]; w = pte[12+mode];
      prot = {r, w, r};
      need = (acc == 2) ? 3'b100 : (acc == 1) ? 3'b010 : 3'b001;
      if ((prot & need) == 0) begin e.fault = 3'd1; return e; end
      prot = prot & ~pte[3:1];
      if ((prot & need) == 0) begin
         e.fault = need[2] ? 3'd3 : (need[1] ? 3'd4 : 3'd2);
         return e;
      end
      e.ok = 1; e.perm = prot; e.pa = {19'h0, pte[63:32], va[12:0]};
      return e;
   endfunction

   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            extra_done++;
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(ok == e.ok, e.tag, "ok", 64'(ok), 64'(e.ok));
            if (!e.ok) check(fault == e.fault, e.tag, "fault", 64'(fault), 64'(e.fault));
            check(paddr == e.pa, e.tag, "paddr", paddr, e.pa);
            check(perm == e.perm, e.tag, "perm", 64'(perm), 64'(e.perm));
            check(rd_log.size() - e.start == e.reads, e.tag, "reads",
                  64'(rd_log.size() - e.start), 64'(e.reads));
         end
      end
   end

   task automatic push_req(logic [63:0] va, int acc, int mode, bit phys, string tag);
      exp_t e;
      e = model(va, acc, mode, phys, ROOT);
      e.tag = tag;
      e.start = rd_log.size();
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_access = 2'(acc); req_mode = 2'(mode);
      req_phys = phys; ptbr = ROOT;
      exp_q.push_back(e);
   endtask

   task automatic do_req(logic [63:0] va, int acc, int mode, bit phys, string tag);
      push_req(va, acc, mode, phys, tag);
      @(negedge clk);
      req_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [63:0] mkva(int i1, int i2, int i3, int off);
      return (64'(i1) << 33) | (64'(i2) << 23) | (64'(i3) << 13) | 64'(off);
   endfunction

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
   end

   initial begin
      int s;
      // tables: root -> L2 at pfn 0x90 -> L3 at pfn 0xA0
      pt_mem[ROOT + 3*8]        = {32'h90, F_V | F_KRE};
      pt_mem[64'h120000 + 5*8]  = {32'hA0, F_V | F_KRE};
      pt_mem[64'h140000 + 7*8]  = {32'h1234, F_V | F_KRE | F_KWE};
      pt_mem[64'h140000 + 8*8]  = {32'h2222, F_V | F_KRE | F_URE};
      pt_mem[64'h140000 + 9*8]  = {32'h3333, F_V | F_KRE | F_KWE | F_FOW};
      pt_mem[64'h140000 + 10*8] = {32'h4444, F_V | F_KRE | F_KWE | F_FOE};
      pt_mem[64'h140000 + 11*8] = {32'h5555, F_V | F_KRE | F_FOR};
      pt_mem[ROOT + 6*8]        = {32'h91, F_V};
      pt_mem[ROOT + 5*8]        = {32'h92, F_V | F_KRE};
      pt_mem[64'h124000 + 3*8]  = {32'hB0, F_V};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      check(done == 1'b0, "R9", "reset done", 64'(done), 0);
      check(busy == 1'b0, "R9", "reset busy", 64'(busy), 0);
      check(mem_req_valid == 1'b0, "R9", "reset read", 64'(mem_req_valid), 0);

      do_req(64'h0000_1000_0000_ABCD, 1, 3, 1'b1, "R1 phys");
      do_req(64'hFFFF_0000_0000_0008, 2, 0, 1'b1, "R1 phys noncanon");
      do_req(64'h0000_1000_0000_0000, 0, 0, 1'b0, "R2 noncanon");
      do_req(64'h8000_0000_0000_0000, 0, 0, 1'b0, "R2 high only");
      do_req(64'hFFFF_FD12_3456_789A, 1, 0, 1'b0, "R3 window kernel");
      do_req(64'hFFFF_FC00_0000_0040, 0, 0, 1'b0, "R3 window bit40 low");
      do_req(64'hFFFF_FD12_3456_789A, 0, 3, 1'b0, "R3 window user");

      s = rd_log.size();
      do_req(mkva(3, 5, 7, 16'h1ABC), 0, 0, 1'b0, "R4 walk read");
      check(rd_log[s]   == 64'h0010_0018, "R4", "L1 addr", rd_log[s],   64'h0010_0018);
      check(rd_log[s+1] == 64'h0012_0028, "R4", "L2 addr", rd_log[s+1], 64'h0012_0028);
      check(rd_log[s+2] == 64'h0014_0038, "R4", "L3 addr", rd_log[s+2], 64'h0014_0038);

      lat = 3;
      do_req(mkva(4, 0, 0, 0), 0, 0, 1'b0, "R5 L1 invalid");
      do_req(mkva(6, 0, 0, 0), 0, 0, 1'b0, "R5 L1 no kre");
      lat = 2;
      do_req(mkva(5, 2, 0, 0), 0, 0, 1'b0, "R5 L2 invalid");
      do_req(mkva(5, 3, 0, 0), 0, 0, 1'b0, "R5 L2 no kre");
      do_req(mkva(3, 5, 12, 0), 0, 0, 1'b0, "R6 L3 invalid");
      do_req(mkva(3, 5, 8, 5), 1, 3, 1'b0, "R7 user write denied");
      do_req(mkva(3, 5, 8, 5), 0, 3, 1'b0, "R7 user read");
      do_req(mkva(3, 5, 8, 5), 2, 3, 1'b0, "R7 user exec");
      do_req(mkva(3, 5, 7, 0), 1, 3, 1'b0, "R7 user no rights");
      lat = 1;
      do_req(mkva(3, 5, 9, 1), 1, 0, 1'b0, "R8 fault on write");
      do_req(mkva(3, 5, 9, 1), 0, 0, 1'b0, "R8 read with fow");
      do_req(mkva(3, 5, 10, 2), 2, 0, 1'b0, "R8 fault on exec");
      do_req(mkva(3, 5, 11, 3), 0, 0, 1'b0, "R8 fault on read");
      do_req(mkva(3, 5, 7, 4), 1, 0, 1'b0, "R8 kernel write");

      // R10: request held during a slow walk must be dropped
      lat = 3;
      push_req(mkva(3, 5, 7, 9), 0, 0, 1'b0, "R10 walk under load");
      @(negedge clk);
      req_phys = 1'b1; req_vaddr = 64'h0000_0000_DEAD_0000;
      repeat (4) @(negedge clk);
      req_valid = 1'b0; req_phys = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (6) @(negedge clk);
      check(extra_done == 0, "R10", "extra done", 64'(extra_done), 0);
      check(busy == 1'b0, "R10", "idle after", 64'(busy), 0);

      report();
      $finish;
   end
endmodule